// File: doc/BRIEF.md
# Wiper Register Adjust Engine

This block owns the 10-bit position register of a digitally controlled potentiometer and applies already-decoded serial commands to it. A frame arrives as a one-cycle strobe carrying a 4-bit command code and 10 data bits. The command can write the position directly, move it one step up or down, halve or double it (a logarithmic step of about 6 dB), or reload it from the stored nonvolatile value. Resistor behaviour is not modelled. The output is the wiper code only: code 0 places the wiper at the B end, code 512 at midscale and code 1023 at the A end.

For push-button control, a step or shift command stays armed after its frame. Each later chip-select strobe that brings no new frame repeats it. Any other frame disarms it. An active-low write-protect input freezes the register against everything except the two restore commands and the hardware preset. An active-low preset input forces midscale while it is low and reloads the stored value when it returns high. On leaving reset, the register loads the stored value, as it would at power-on.

Top module: `wiper_engine`

## Requirements
- R1: While reset is asserted the wiper reads 512. At the first clock edge after reset is released, the wiper takes `nv_value`.
- R2: A frame with code 11 loads `cmd_data` into the wiper at the next clock edge.
- R3: Codes 14 and 15 add one and stop at 1023. Codes 6 and 7 subtract one and stop at 0. Neither wraps.
- R4: Codes 12 and 13 double the wiper. A value of 512 or more gives 1023, and 0 gives 1.
- R5: Codes 4 and 5 halve the wiper, discarding the low bit. 0 stays 0.
- R6: Codes 1 and 8 load `nv_value` into the wiper.
- R7: After a step or shift frame (codes 4, 5, 6, 7, 12, 13, 14, 15), each `strobe_only` pulse that comes without a frame applies that same operation again.
- R8: Every other frame leaves the repeat disarmed, and a later `strobe_only` then leaves the wiper unchanged. Those frames are code 0 (no-operation), codes 1, 8 and 11, and the unused codes 2, 3, 9 and 10. Codes 0, 2, 3, 9 and 10 never change the wiper.
- R9: While `wp_n` is low, frames and repeats leave the wiper unchanged, except that codes 1 and 8 still load `nv_value` and the preset still acts.
- R10: While `preset_n` is sampled low, the wiper becomes and stays 512. At the first edge where `preset_n` is sampled high again, the wiper takes `nv_value`.
- R11: The preset, and the load after it, take priority over any frame in the same cycle. A frame takes priority over `strobe_only` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| cmd_code | input | 4 | Command code of the frame |
| cmd_data | input | 10 | Data bits of the frame |
| strobe_only | input | 1 | Chip-select strobe that carried no new frame |
| wp_n | input | 1 | Write protect, active low |
| preset_n | input | 1 | Hardware preset, active low, sampled on the clock |
| nv_value | input | 10 | Stored nonvolatile wiper value |
| wiper | output | 10 | Current wiper code |

## Verification
The bound checker watches the following on every cycle:
- the preset forcing midscale, and the reload on its release;
- direct writes;
- single steps, including saturation at both ends;
- the freeze under write protect.

Longer histories can only be shown by the bench's scenarios. These include:
- repetition across several strobes;
- disarming by a no-operation or unused code;
- restore values changing between frames;
- a frame and a strobe arriving together.

A constrained random run is compared every cycle with a bench model written directly from the code table.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_RESTORE, OP_INC, OP_DEC, OP_SHL, OP_SHR
  } op_e;

  localparam int CODE_W = 4;

  function automatic logic is_adjust(op_e op);
    return (op == OP_INC) || (op == OP_DEC) || (op == OP_SHL) || (op == OP_SHR);
  endfunction
endpackage

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
  import wiper_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output op_e               op
);
  always_comb begin
    case (code)
      4'd11:        op = OP_WRITE;
      4'd1, 4'd8:   op = OP_RESTORE;
      4'd14, 4'd15: op = OP_INC;
      4'd6, 4'd7:   op = OP_DEC;
      4'd12, 4'd13: op = OP_SHL;
      4'd4, 4'd5:   op = OP_SHR;
      default:      op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/wiper_repeat.sv
module wiper_repeat
  import wiper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic strobe_only,
  input  op_e  frame_op,
  output op_e  op_eff
);
  op_e armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= OP_NONE;
    else if (cmd_valid) armed_q <= is_adjust(frame_op) ? frame_op : OP_NONE;
  end

  always_comb begin
    if (cmd_valid)        op_eff = frame_op;
    else if (strobe_only) op_eff = armed_q;
    else                  op_eff = OP_NONE;
  end
endmodule

// File: rtl/wiper_reg.sv
module wiper_reg
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  op_e          op_eff,
  input  logic [W-1:0] data,
  input  logic         wp_n,
  input  logic         preset_n,
  input  logic [W-1:0] nv_value,
  output logic [W-1:0] wiper,
  output logic         apply_en,
  output logic         load_nv,
  output logic         preset_rise
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] step_up(logic [W-1:0] v);
    return (v == TOP) ? TOP : v + W'(1);
  endfunction

  function automatic logic [W-1:0] step_down(logic [W-1:0] v);
    return (v == '0) ? '0 : v - W'(1);
  endfunction

  function automatic logic [W-1:0] dbl(logic [W-1:0] v);
    if (v == '0)       return W'(1);
    else if (v[W-1])   return TOP;
    else               return v << 1;
  endfunction

  function automatic logic [W-1:0] half(logic [W-1:0] v);
    return v >> 1;
  endfunction

  logic         preset_q, boot_q;
  logic [W-1:0] adj_val;

  assign preset_rise = preset_n && !preset_q;
  assign load_nv     = preset_n && (preset_rise || boot_q);
  assign apply_en    = preset_n && !load_nv && (op_eff != OP_NONE) &&
                       (wp_n || (op_eff == OP_RESTORE));

  always_comb begin
    case (op_eff)
      OP_WRITE:   adj_val = data;
      OP_RESTORE: adj_val = nv_value;
      OP_INC:     adj_val = step_up(wiper);
      OP_DEC:     adj_val = step_down(wiper);
      OP_SHL:     adj_val = dbl(wiper);
      OP_SHR:     adj_val = half(wiper);
      default:    adj_val = wiper;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper    <= MID;
      preset_q <= 1'b1;
      boot_q   <= 1'b1;
    end else begin
      preset_q <= preset_n;
      boot_q   <= 1'b0;
      if (!preset_n)     wiper <= MID;
      else if (load_nv)  wiper <= nv_value;
      else if (apply_en) wiper <= adj_val;
    end
  end
endmodule

// File: rtl/wiper_engine.sv
module wiper_engine
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [W-1:0]      cmd_data,
  input  logic              strobe_only,
  input  logic              wp_n,
  input  logic              preset_n,
  input  logic [W-1:0]      nv_value,
  output logic [W-1:0]      wiper
);
  op_e  frame_op, op_eff;
  logic apply_en, load_nv, preset_rise;

  wiper_cmd_decode u_dec (.code(cmd_code), .op(frame_op));

  wiper_repeat u_rep (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .strobe_only(strobe_only),
    .frame_op(frame_op), .op_eff(op_eff)
  );

  wiper_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .op_eff(op_eff), .data(cmd_data), .wp_n(wp_n),
    .preset_n(preset_n), .nv_value(nv_value), .wiper(wiper), .apply_en(apply_en),
    .load_nv(load_nv), .preset_rise(preset_rise)
  );
endmodule

// File: rtl/wiper_engine_chk.sv
module wiper_engine_chk
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [CODE_W-1:0] cmd_code,
  input logic [W-1:0]      cmd_data,
  input logic              wp_n,
  input logic              preset_n,
  input logic [W-1:0]      nv_value,
  input logic [W-1:0]      wiper,
  input op_e               op_eff,
  input logic              apply_en,
  input logic              load_nv,
  input logic              preset_rise
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic restore_frame;
  assign restore_frame = cmd_valid && ((cmd_code == 4'd1) || (cmd_code == 4'd8));

  a_r10_preset_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |=> wiper == MID);

  a_r10_preset_reload: assert property (@(posedge clk) disable iff (!rst_n)
    preset_rise |=> wiper == $past(nv_value));

  a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 4'd11 && wp_n && preset_n && !load_nv)
      |=> wiper == $past(cmd_data));

  a_r9_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && preset_n && !load_nv && !restore_frame) |=> $stable(wiper));

  a_r3_top_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_en && op_eff == OP_INC && wiper == TOP) |=> wiper == TOP);

  a_r3_bottom_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_en && op_eff == OP_DEC && wiper == '0) |=> wiper == '0);

  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_en && op_eff == OP_INC && wiper != TOP) |=> wiper == $past(wiper) + W'(1));
endmodule

bind wiper_engine wiper_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_data(cmd_data), .wp_n(wp_n), .preset_n(preset_n), .nv_value(nv_value),
  .wiper(wiper), .op_eff(op_eff), .apply_en(apply_en), .load_nv(load_nv),
  .preset_rise(preset_rise)
);

// File: tb/wiper_engine_tb.sv
`timescale 1ns/1ps
module wiper_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, strobe_only = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic [9:0] cmd_data = 10'd0, nv_value = 10'd300;
  logic       wp_n = 1'b1, preset_n = 1'b1;
  logic [9:0] wiper;

  int checks = 0, errors = 0;
  int m_w, m_rep, m_pq, m_boot;

  always #2.5 clk = ~clk;

  wiper_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .strobe_only(strobe_only), .wp_n(wp_n),
    .preset_n(preset_n), .nv_value(nv_value), .wiper(wiper)
  );

  function automatic bit armable(int c);
    return (c inside {4, 5, 6, 7, 12, 13, 14, 15});
  endfunction

  function automatic int apply(int c, int w, int d, int nv);
    case (c)
      11:      return d;
      1, 8:    return nv;
      14, 15:  return (w >= 1023) ? 1023 : w + 1;
      6, 7:    return (w <= 0) ? 0 : w - 1;
      12, 13:  return (w == 0) ? 1 : ((w * 2 > 1023) ? 1023 : w * 2);
      4, 5:    return w / 2;
      default: return w;
    endcase
  endfunction

  task automatic model_step();
    int eff;
    eff = -1;
    if (cmd_valid) eff = cmd_code;
    else if (strobe_only) eff = m_rep;
    if (cmd_valid) m_rep = armable(cmd_code) ? int'(cmd_code) : -1;
    if (!preset_n) m_w = 512;
    else if ((m_pq == 0) || (m_boot != 0)) m_w = nv_value;
    else if (eff >= 0 && (wp_n || eff == 1 || eff == 8))
      m_w = apply(eff, m_w, cmd_data, nv_value);
    m_pq = preset_n;
    m_boot = 0;
  endtask

  task automatic check(string tag, int exp);
    checks++;
    if (int'(wiper) !== exp) begin
      errors++;
      $display("FAIL %s: wiper=%0d expected=%0d", tag, wiper, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after the rising edge
  task automatic go(bit v, int c, int d, bit s, bit wp, bit pr, int nv);
    @(negedge clk);
    cmd_valid = v; cmd_code = 4'(c); cmd_data = 10'(d);
    strobe_only = s; wp_n = wp; preset_n = pr; nv_value = 10'(nv);
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
    cmd_valid = 1'b0; strobe_only = 1'b0;
  endtask

  task automatic frm(int c, int d, int nv);
    go(1'b1, c, d, 1'b0, 1'b1, 1'b1, nv);
  endtask

  task automatic stb(int nv);
    go(1'b0, 0, 0, 1'b1, 1'b1, 1'b1, nv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: wiper=%0d expected=finished", wiper);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_w = 512; m_rep = -1; m_pq = 1; m_boot = 1;
    repeat (3) @(posedge clk);
    #1 check("R1 reset value", 512);
    @(negedge clk) rst_n = 1'b1;
    go(1'b0, 0, 0, 1'b0, 1'b1, 1'b1, 300); check("R1 boot load", 300);

    frm(11, 0, 300);   check("R2 write", 0);
    frm(6, 0, 300);    check("R3 floor", 0);
    frm(14, 0, 300);   check("R3 inc", 1);
    stb(300);          check("R7 repeat inc", 2);
    stb(300);          check("R7 repeat inc again", 3);
    frm(7, 0, 300);    check("R3 dec", 2);
    frm(15, 0, 300);   check("R3 inc alt", 3);
    frm(11, 1023, 300); frm(15, 0, 300); check("R3 ceiling", 1023);
    frm(13, 0, 300);   check("R4 double top", 1023);
    frm(11, 0, 300); frm(12, 0, 300); check("R4 zero to one", 1);
    stb(300);          check("R7 repeat shl", 2);
    stb(300);          check("R7 repeat shl again", 4);
    frm(11, 600, 300); frm(12, 0, 300); check("R4 saturate", 1023);
    frm(11, 511, 300); frm(13, 0, 300); check("R4 double", 1022);
    frm(11, 0, 300); frm(4, 0, 300);    check("R5 zero", 0);
    frm(11, 9, 300); frm(5, 0, 300);    check("R5 halve", 4);
    stb(300);          check("R7 repeat shr", 2);
    frm(0, 0, 300);    check("R8 nop", 2);
    stb(300);          check("R8 nop disarms", 2);
    frm(14, 0, 300);   check("R3 inc", 3);
    frm(3, 5, 300);    check("R8 unused code", 3);
    stb(300);          check("R8 unused disarms", 3);
    frm(1, 0, 77);     check("R6 restore 1", 77);
    frm(8, 0, 88);     check("R6 restore 8", 88);
    go(1'b1, 11, 5, 1'b0, 1'b0, 1'b1, 88); check("R9 write blocked", 88);
    go(1'b1, 14, 0, 1'b0, 1'b0, 1'b1, 88); check("R9 step blocked", 88);
    go(1'b0, 0, 0, 1'b1, 1'b0, 1'b1, 88);  check("R9 repeat blocked", 88);
    go(1'b1, 8, 0, 1'b0, 1'b0, 1'b1, 99);  check("R9 restore allowed", 99);
    go(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 99);  check("R9 R10 preset low", 512);
    go(1'b1, 11, 5, 1'b0, 1'b1, 1'b0, 99); check("R11 preset over frame", 512);
    go(1'b1, 11, 5, 1'b0, 1'b1, 1'b1, 200); check("R10 R11 reload on rise", 200);
    frm(14, 0, 200);   check("R3 inc", 201);
    go(1'b1, 11, 40, 1'b1, 1'b1, 1'b1, 200); check("R11 frame over strobe", 40);
    stb(200);          check("R8 write disarms", 40);

    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      bit v, s, wp, pr;
      int c, d, nv;
      v  = ($urandom_range(0, 9) < 4);
      s  = ($urandom_range(0, 9) < 4);
      wp = ($urandom_range(0, 9) != 0);
      pr = ($urandom_range(0, 19) != 0);
      c  = $urandom_range(0, 15);
      d  = (i % 7 == 0) ? 1023 : $urandom_range(0, 1023);
      nv = $urandom_range(0, 1023);
      go(v, c, d, s, wp, pr, nv);
      check("R2-R11 random vs model", m_w);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule